// File: doc/BRIEF.md
# Reset-Gated Chip-Enable Controller

This block sits between a processor's active-low RAM chip-enable and the memory itself. While the system is out of reset, the strobe passes straight through with no register in its path. When the reset generator asserts reset, or is still counting out its post-reset timeout, the block closes the path. The output is then held high, so no write can land in memory while the supply is undervoltage.

A write cycle may already be running when reset arrives. In that case the chip-enable stays low for a bounded grace window of `GRACE_CYC` clock edges, or until the processor releases the strobe, whichever comes first. After that the gate shuts. A closed gate stays closed for the whole time reset and its timeout are active, whatever the input does. It reopens only at the first clock edge that sees both flags low. A status output reports whether the gate is passing the input. When it is not passing, the input is treated as high impedance.

Top module: `cegate_ctrl`

## Requirements
- R1: With the hold condition low at the previous and the current clock edge, `ce_out_no` equals `ce_in_ni` combinationally.
- R2: `ce_out_no` is low only while `ce_in_ni` is low.
- R3: If hold rises while `ce_in_ni` is high, `ce_out_no` stays high and `gate_en_o` is 0 after the first clock edge that sees hold.
- R4: If hold rises while `ce_in_ni` is low and the input stays low, `ce_out_no` stays low through exactly `GRACE_CYC` clock edges, counted from the first edge that sees hold. It is high after edge number `GRACE_CYC` + 1.
- R5: During the grace window, a rising `ce_in_ni` drives `ce_out_no` high at once, and `gate_en_o` is 0 after the next clock edge.
- R6: Once the gate is closed it stays closed while hold is high: `ce_out_no` = 1 and `gate_en_o` = 0, and a new falling `ce_in_ni` has no effect.
- R7: The hold condition is `rst_act_i` OR `tmo_act_i`. The timeout flag alone keeps a closed gate closed.
- R8: `gate_en_o` is 1 in the open and grace phases and 0 when the gate is closed. A 0 means the input is treated as high impedance and the output is driven high.
- R9: After hold falls, the gate stays closed until the first clock edge that sees hold low. After that edge `gate_en_o` = 1 and the output follows the input.
- R10: `rst_ni` low asynchronously puts the block in the open phase (`gate_en_o` = 1).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset of this block |
| ce_in_ni | input | 1 | Chip-enable from the processor, active low |
| rst_act_i | input | 1 | Reset asserted by the reset generator |
| tmo_act_i | input | 1 | Reset timeout still counting |
| ce_out_no | output | 1 | Gated chip-enable to the RAM, active low |
| gate_en_o | output | 1 | 1 while the gate passes the input; 0 when closed (input treated as high impedance) |

## Verification
The following are checked on every cycle:
- The output never goes low unless the input is low.
- With hold off, the output follows the input.
- A closed gate stays closed while hold is high.
- A rising hold with a high input closes the gate at the next edge.
- The grace counter never passes its last value.

The exact length of the grace window can only be shown by the bench's sweeps, which release the input at every offset across the window. The same holds for these behaviours:
- The timeout flag alone keeps the gate closed.
- The gate reopens exactly one edge after hold clears.
- Asynchronous reset acts without a clock edge.

// File: rtl/cegate_pkg.sv
package cegate_pkg;
  typedef enum logic [1:0] {
    GS_OPEN  = 2'd0,
    GS_GRACE = 2'd1,
    GS_SHUT  = 2'd2
  } gate_st_e;
endpackage

// File: rtl/cegate_timer.sv
module cegate_timer #(
  parameter int unsigned GRACE_CYC = 750
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expired_o
);
  localparam int unsigned CNT_W = (GRACE_CYC > 1) ? $clog2(GRACE_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(GRACE_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (!run_i)               cnt_q <= '0;
    else if (cnt_q != LAST)        cnt_q <= cnt_q + CNT_W'(1);
  end

  assign expired_o = run_i && (cnt_q == LAST);

  assert_grace_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/cegate_fsm.sv
module cegate_fsm
  import cegate_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     hold_i,
  input  logic     ce_low_i,
  input  logic     expired_i,
  output gate_st_e state_o,
  output logic     run_o
);
  gate_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      GS_OPEN:  if (hold_i) st_d = ce_low_i ? GS_GRACE : GS_SHUT;
      GS_GRACE: begin
        if (!hold_i)                     st_d = GS_OPEN;
        else if (!ce_low_i || expired_i) st_d = GS_SHUT;
      end
      GS_SHUT:  if (!hold_i) st_d = GS_OPEN;
      default:  st_d = GS_SHUT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= GS_OPEN;
    else         st_q <= st_d;
  end

  assign state_o = st_q;
  assign run_o   = (st_q == GS_GRACE);

  assert_shut_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(st_q == GS_SHUT) && $past(hold_i)) |-> (st_q == GS_SHUT));
endmodule

// File: rtl/cegate_outmux.sv
module cegate_outmux
  import cegate_pkg::*;
(
  input  gate_st_e state_i,
  input  logic     ce_in_ni,
  output logic     ce_out_no,
  output logic     gate_en_o
);
  // closed gate: output pulled high, input seen as high impedance
  assign gate_en_o = (state_i != GS_SHUT);
  assign ce_out_no = gate_en_o ? ce_in_ni : 1'b1;
endmodule

// File: rtl/cegate_ctrl.sv
module cegate_ctrl
  import cegate_pkg::*;
#(
  parameter int unsigned GRACE_CYC = 750
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ce_in_ni,
  input  logic rst_act_i,
  input  logic tmo_act_i,
  output logic ce_out_no,
  output logic gate_en_o
);
  logic     hold;
  logic     run;
  logic     expired;
  gate_st_e state;

  assign hold = rst_act_i | tmo_act_i;

  cegate_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hold_i    (hold),
    .ce_low_i  (!ce_in_ni),
    .expired_i (expired),
    .state_o   (state),
    .run_o     (run)
  );

  cegate_timer #(.GRACE_CYC(GRACE_CYC)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .expired_o (expired)
  );

  cegate_outmux u_mux (
    .state_i   (state),
    .ce_in_ni  (ce_in_ni),
    .ce_out_no (ce_out_no),
    .gate_en_o (gate_en_o)
  );

  assert_low_needs_in_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_out_no |-> !ce_in_ni);

  assert_follow_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold && $past(!hold)) |-> (ce_out_no == ce_in_ni));

  assert_idle_close_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(hold) && ce_in_ni) |=> !gate_en_o);

  assert_shut_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!gate_en_o) && $past(hold) && hold) |-> (ce_out_no && !gate_en_o));
endmodule

// File: tb/sim_cegate_ctrl.sv
`timescale 1ns/1ps
module sim_cegate_ctrl;
  localparam int G = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_in_n = 1'b1;
  logic rst_act = 1'b0;
  logic tmo_act = 1'b0;
  logic ce_out_n, gate_en;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cegate_ctrl #(.GRACE_CYC(G)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .ce_in_ni(ce_in_n),
    .rst_act_i(rst_act), .tmo_act_i(tmo_act),
    .ce_out_no(ce_out_n), .gate_en_o(gate_en)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // move just past a rising edge; drive and sample there
  task automatic step();
    @(posedge clk);
    #3;
  endtask

  initial begin
    #5;
    chk("R10 reset gate_en", gate_en, 1'b1);
    chk("R10 reset out", ce_out_n, 1'b1);
    step(); step();
    rst_n = 1'b1;
    step();

    // R1: pass-through pattern
    for (int i = 0; i < 10; i++) begin
      ce_in_n = logic'((i * 7 + 3) % 3 == 0);
      #1;
      chk("R1 follow", ce_out_n, ce_in_n);
      chk("R8 open status", gate_en, 1'b1);
      step();
    end

    // R4/R5 sweep: raise input at iteration m (0 = never)
    for (int m = 0; m <= G + 1; m++) begin
      ce_in_n = 1'b0; rst_act = 1'b0; tmo_act = 1'b0;
      step();
      rst_act = 1'b1;
      #1;
      chk("R4 low at hold rise", ce_out_n, 1'b0);
      for (int e = 1; e <= G + 2; e++) begin
        step();
        if (m != 0 && e == m) ce_in_n = 1'b1;
        #1;
        chk((m == 0) ? "R4 grace out" : "R5 grace out", ce_out_n,
            !((e <= G) && (m == 0 || e < m)));
        chk("R5 grace status", gate_en, (e <= G) && (m == 0 || e <= m));
        chk("R2 low needs in", !ce_out_n && ce_in_n, 1'b0);
      end
      // R6: new falling input ignored while closed
      ce_in_n = 1'b0;
      #1;
      chk("R6 refall out", ce_out_n, 1'b1);
      step();
      chk("R6 refall out later", ce_out_n, 1'b1);
      chk("R6 status", gate_en, 1'b0);
      // R7: timeout flag alone holds
      rst_act = 1'b0; tmo_act = 1'b1;
      step(); step();
      chk("R7 tmo holds out", ce_out_n, 1'b1);
      chk("R7 tmo holds status", gate_en, 1'b0);
      // R9: reopen one edge after hold clears
      tmo_act = 1'b0;
      #1;
      chk("R9 still shut", ce_out_n, 1'b1);
      step();
      chk("R9 reopened out", ce_out_n, 1'b0);
      chk("R9 reopened status", gate_en, 1'b1);
      ce_in_n = 1'b1;
      step();
    end

    // R3: hold rises with input high
    ce_in_n = 1'b1;
    step();
    tmo_act = 1'b1;
    #1;
    chk("R3 out high", ce_out_n, 1'b1);
    chk("R3 status before edge", gate_en, 1'b1);
    step();
    chk("R3 status closed", gate_en, 1'b0);
    ce_in_n = 1'b0;
    #1;
    chk("R3 input ignored", ce_out_n, 1'b1);
    step();

    // R10: async reset reopens without a clock edge
    tmo_act = 1'b0;
    #2;
    rst_n = 1'b0;
    #1;
    chk("R10 async status", gate_en, 1'b1);
    chk("R10 async follow", ce_out_n, 1'b0);
    step();
    rst_n = 1'b1;
    step();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule